// File: doc/BRIEF.md
# Four-Channel Compare Timer

This block is a free-running up-counter with a power-of-two clock divider, a counter width picked at run time, and four compare channels. Software drives it through a small word-addressed register port. Three task registers start, stop and zero the counter. Each compare channel holds a 32-bit value and a sticky event flag. The flag sets when the counter steps onto that channel's value and stays set until software writes zero to it.

The counter wraps to zero at the top of the selected width. A compare value that lies behind the current count therefore fires only after the counter has wrapped. The event flags also leave the block as a registered vector, so a neighbouring block can react to them without polling the register port.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count reads 0, the timer is stopped (state register 0), the width mode reads 3, the divider exponent reads 0, every compare value reads 0 and every event flag reads 0.
- R2: A write to the start task (address 0) with data bit 0 set puts the timer in the running state. A write with bit 0 clear has no effect.
- R3: A write to the stop task (address 1) with bit 0 set leaves the running state. While stopped the count holds its value.
- R4: A write to the clear task (address 2) with bit 0 set sets the count to 0 and restarts the divider phase. It does not change the running state.
- R5: The divider exponent register (address 4) holds p. While running, the count advances once every 2^p cycles. A written value above 9 is stored as 9.
- R6: Width mode register (address 3, bits 1:0) selects 8, 16, 24 or 32 bits for values 0 to 3. The count advances modulo 2^width, and reads of the count (address 5) return it masked to the width.
- R7: On the clock edge at which the count steps onto a channel's compare value (both masked to the width), that channel's event flag becomes 1. A clear does not fire a flag. The flag stays 1 until cleared.
- R8: A write of 0 to a channel's event register (addresses 12 to 15) clears its flag. A nonzero write is ignored. If a step onto the compare value happens on the same edge as the clearing write, the flag is set.
- R9: A compare value below the current count raises its flag only after the counter wraps to 0 and climbs to the value again.
- R10: Compare values (addresses 8 to 11) read back as written at full 32 bits. The state register (address 6) returns the running bit. A read returns the values from before the edge, in the cycle after the read, and read data holds while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_o | output | 4 | Registered compare event flags, bit n is channel n |

## Verification
The bench builds the block with its defaults: a 32-bit counter, four channels and a divider exponent limit of 9. Its reference model compares the event vector on every clock and the read data after every read. Running in 8-bit mode brings the wrap within about 256 cycles. That lets the bench reach a late-firing compare that sits behind the count, an aliased compare value above the width, and the wrap to zero. Exponent 3 exercises the divided cadence. A clearing write timed onto the matching edge covers the set-over-clear rule.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] ADR_START = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_STOP  = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_CLEAR = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_WIDTH = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_PSC   = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_COUNT = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_STATE = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_CMP0  = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_EVT0  = 4'd12;
  localparam logic [1:0]        MODE_RST  = 2'd3;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W   = 4,
  parameter int PSC_MAX = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int PH_W = (PSC_MAX > 0) ? PSC_MAX : 1;

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] dmask;

  // low p bits of the phase all ones marks the end of a 2^p window
  always_comb begin
    for (int b = 0; b < PH_W; b++) dmask[b] = (b < int'(psc));
  end

  assign tick = run & ~clr & ((phase & dmask) == dmask);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  a_r5_phase_idle: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (phase == '0));
  a_r5_full_rate: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && psc == '0) |-> tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic [1:0]       mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] mask
);
  always_comb begin
    for (int b = 0; b < CNT_W; b++) mask[b] = (b < (int'(mode) + 1) * BYTE_W);
  end

  always_comb begin
    if (clr)       cnt_nxt = '0;
    else if (tick) cnt_nxt = (cnt_q + 1'b1) & mask;
    else           cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt_q));
  a_r4_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && ((cnt_q & mask) == mask)) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             evt_clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] mask,
  output logic [CNT_W-1:0] cmp_q,
  output logic             evt_q
);
  logic hit;

  assign hit = tick && ((cnt_nxt & mask) == (cmp_q & mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      evt_q <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= cmp_wdata;
      if (hit)          evt_q <= 1'b1;
      else if (evt_clr) evt_q <= 1'b0;
    end
  end

  a_r7_set: assert property (@(posedge clk) disable iff (rst)
    hit |=> evt_q);
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (evt_q && !evt_clr) |=> evt_q);
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (evt_clr && !hit) |=> !evt_q);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NCH     = 4,
  parameter int PSC_W   = 4,
  parameter int PSC_MAX = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    evt_o
);
  logic             run_q;
  logic [1:0]       mode_q;
  logic [PSC_W-1:0] psc_q;
  logic             do_start, do_stop, do_clr, tick;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, mask;
  logic [CNT_W-1:0] cmp_val [NCH];
  logic [NCH-1:0]   evt_q;
  logic [31:0]      rd_n;

  assign do_start = bus_wr && bus_addr == ADR_START && bus_wdata[0];
  assign do_stop  = bus_wr && bus_addr == ADR_STOP  && bus_wdata[0];
  assign do_clr   = bus_wr && bus_addr == ADR_CLEAR && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      mode_q <= MODE_RST;
      psc_q  <= '0;
    end else begin
      if (do_start)     run_q <= 1'b1;
      else if (do_stop) run_q <= 1'b0;
      if (bus_wr && bus_addr == ADR_WIDTH) mode_q <= bus_wdata[1:0];
      if (bus_wr && bus_addr == ADR_PSC)
        psc_q <= (bus_wdata > 32'(PSC_MAX)) ? PSC_W'(PSC_MAX) : bus_wdata[PSC_W-1:0];
    end
  end

  tmr_prescaler #(.PSC_W(PSC_W), .PSC_MAX(PSC_MAX)) u_psc (
    .clk(clk), .rst(rst), .run(run_q), .clr(do_clr), .psc(psc_q), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clr(do_clr), .mode(mode_q),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .mask(mask)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic cmp_we, evt_clr;
    assign cmp_we  = bus_wr && bus_addr == (ADR_CMP0 + 4'(i));
    assign evt_clr = bus_wr && bus_addr == (ADR_EVT0 + 4'(i)) && bus_wdata == '0;
    tmr_cmp_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_wdata(bus_wdata[CNT_W-1:0]),
      .evt_clr(evt_clr), .tick(tick), .cnt_nxt(cnt_nxt), .mask(mask),
      .cmp_q(cmp_val[i]), .evt_q(evt_q[i])
    );
  end

  always_comb begin
    rd_n = '0;
    case (bus_addr)
      ADR_WIDTH: rd_n = 32'(mode_q);
      ADR_PSC:   rd_n = 32'(psc_q);
      ADR_COUNT: rd_n = 32'(cnt_q & mask);
      ADR_STATE: rd_n = 32'(run_q);
      default:   rd_n = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADR_CMP0 + 4'(i)) rd_n = 32'(cmp_val[i]);
      if (bus_addr == ADR_EVT0 + 4'(i)) rd_n = 32'(evt_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_n;
  end

  assign evt_o = evt_q;

  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    do_start |=> run_q);
  a_r3_stop: assert property (@(posedge clk) disable iff (rst)
    do_stop |=> !run_q);
  a_r4_keep_state: assert property (@(posedge clk) disable iff (rst)
    (do_clr) |=> (run_q == $past(run_q)));
  a_r5_psc_range: assert property (@(posedge clk) disable iff (rst)
    psc_q <= PSC_W'(PSC_MAX));
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd) |=> $stable(bus_rdata));
endmodule

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  evt_o;

  int n_chk = 0, n_fail = 0;
  string req_tag = "R1";

  always #4 clk = ~clk;

  cmp_timer dut (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_o(evt_o));

  // behavioural reference model
  logic [31:0] m_cnt, m_rdata, m_psc, m_pre;
  logic [31:0] m_cc [4];
  logic [1:0]  m_mode;
  logic [3:0]  m_evt;
  logic        m_run, m_rdv;

  function automatic logic [31:0] width_mask(input logic [1:0] md);
    return (md == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << ((int'(md) + 1) * 8)) - 1);
  endfunction

  always @(posedge clk) begin
    logic [31:0] msk, dm, nxt;
    logic clr, tck;
    if (rst) begin
      m_cnt = 0; m_run = 0; m_pre = 0; m_psc = 0; m_mode = 2'd3; m_evt = 0;
      m_rdv = 0; m_rdata = 0;
      for (int i = 0; i < 4; i++) m_cc[i] = 0;
    end else begin
      msk = width_mask(m_mode);
      dm  = (32'h1 << m_psc) - 1;
      clr = bus_wr && bus_addr == 4'd2 && bus_wdata[0];
      tck = m_run && !clr && ((m_pre & dm) == dm);
      m_rdv = bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          4'd3: m_rdata = 32'(m_mode);
          4'd4: m_rdata = m_psc;
          4'd5: m_rdata = m_cnt & msk;
          4'd6: m_rdata = 32'(m_run);
          4'd8, 4'd9, 4'd10, 4'd11: m_rdata = m_cc[bus_addr - 4'd8];
          4'd12, 4'd13, 4'd14, 4'd15: m_rdata = 32'(m_evt[bus_addr - 4'd12]);
          default: m_rdata = 0;
        endcase
      end
      nxt = clr ? 0 : (tck ? ((m_cnt + 1) & msk) : m_cnt);
      for (int i = 0; i < 4; i++) begin
        if (tck && nxt == (m_cc[i] & msk)) m_evt[i] = 1'b1;
        else if (bus_wr && bus_addr == 4'(12 + i) && bus_wdata == 0) m_evt[i] = 1'b0;
      end
      m_pre = (clr || !m_run) ? 0 : ((m_pre + 1) & 32'h1FF);
      if (bus_wr && bus_addr == 4'd0 && bus_wdata[0]) m_run = 1;
      else if (bus_wr && bus_addr == 4'd1 && bus_wdata[0]) m_run = 0;
      if (bus_wr) begin
        if (bus_addr == 4'd3) m_mode = bus_wdata[1:0];
        if (bus_addr == 4'd4) m_psc = (bus_wdata > 9) ? 9 : bus_wdata;
        if (bus_addr >= 4'd8 && bus_addr <= 4'd11) m_cc[bus_addr - 4'd8] = bus_wdata;
      end
      m_cnt = nxt;
    end
  end

  // comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (evt_o !== m_evt) begin
        n_fail++;
        $display("FAIL %s/R7 evt_o actual=%b expected=%b", req_tag, evt_o, m_evt);
      end
      if (m_rdv) begin
        n_chk++;
        if (bus_rdata !== m_rdata) begin
          n_fail++;
          $display("FAIL %s rdata actual=%h expected=%h", req_tag, bus_rdata, m_rdata);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
  endtask
  task automatic rd(input logic [3:0] a);
    @(negedge clk); bus_wr = 0; bus_rd = 1; bus_addr = a; bus_wdata = 0;
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) rd(4'd5);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    req_tag = "R1";
    rd(4'd5); rd(4'd6); rd(4'd3); rd(4'd4); rd(4'd8);
    for (int i = 0; i < 4; i++) rd(4'(12 + i));
    // R2 start: zero data ignored, then real start
    req_tag = "R2";
    wr(4'd0, 32'h0); idle(3); rd(4'd6);
    wr(4'd0, 32'h1); idle(20); rd(4'd6);
    // R3 stop freezes count
    req_tag = "R3";
    wr(4'd1, 32'h1); idle(6); rd(4'd6);
    // R4 clear while stopped and while running
    req_tag = "R4";
    wr(4'd2, 32'h1); idle(2); rd(4'd6);
    wr(4'd0, 32'h1); idle(5);
    wr(4'd2, 32'h1); idle(5); rd(4'd6);
    // R5 divided rate and clamp
    req_tag = "R5";
    wr(4'd4, 32'd3); wr(4'd2, 32'h1); idle(40);
    wr(4'd4, 32'd12); rd(4'd4);
    wr(4'd4, 32'd1); idle(10); wr(4'd4, 32'd0);
    // R6 8-bit wrap, then 16-bit mode readback
    req_tag = "R6";
    wr(4'd3, 32'd0); wr(4'd2, 32'h1); idle(270);
    wr(4'd3, 32'd1); rd(4'd3); idle(5); wr(4'd3, 32'd0);
    // R7 and R8: set wins over a same-edge clear, nonzero ignored
    req_tag = "R8";
    wr(4'd1, 32'h1); wr(4'd2, 32'h1);
    for (int i = 0; i < 4; i++) wr(4'(12 + i), 32'h0);
    wr(4'd8, 32'd20); wr(4'd9, 32'h105); wr(4'd10, 32'd200); wr(4'd11, 32'd250);
    req_tag = "R7";
    wr(4'd0, 32'h1); idle(19); wr(4'd12, 32'h0);
    idle(3); rd(4'd12);
    req_tag = "R8";
    wr(4'd12, 32'h5); idle(2); rd(4'd12);
    wr(4'd12, 32'h0); idle(2); rd(4'd12);
    // R9 compare behind the count fires only after wrap
    req_tag = "R9";
    wr(4'd10, 32'd10); wr(4'd14, 32'h0); idle(100); rd(4'd14);
    idle(150); rd(4'd14);
    // R10 full-width compare readback while 16-bit mode aliases it
    req_tag = "R10";
    wr(4'd3, 32'd1); wr(4'd11, 32'h0001_0003); wr(4'd2, 32'h1); idle(6);
    rd(4'd11); rd(4'd15); rd(4'd7); rd(4'd0);
    @(negedge clk); bus_rd = 0; bus_wr = 0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule